// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This block turns an operand specifier into an effective address and an operand value for a small load/store datapath. A request carries a 4-bit mode code, a primary register number, a secondary (index) register number, a short address/displacement field and the current program counter. The unit owns a small register file. It makes up to two word reads through a request/acknowledge memory port. It applies any automatic register update and pulses `done` when the operand and the effective address are valid.

Eleven modes are supported:
- immediate and register operands, which need no memory access;
- direct and register-indirect addressing;
- a memory-indirect mode that first fetches a pointer;
- indexed, based-indexed, base-relative and PC-relative sums;
- post-increment and pre-decrement pointer modes for walking arrays and stacks.

The register file is loaded through a simple write port. Its contents can be observed with the register mode.

Top module: `opnd_addr_unit`

## Requirements
- R1: After reset `done`, `busy`, `mem_req` and `illegal` are low, and every register of the file reads as zero.
- R2: Mode code 0 (immediate) and 1 (register) complete with `done` in the cycle after the accepted `start` and make no memory request. The operand is the field sign-extended to the word width (code 0) or the content of the primary register (code 1), and `ea` is zero.
- R3: Mode 3 (direct) reads memory at the field zero-extended, and mode 2 (register indirect) reads it at the primary register's value. In both, `ea` is that address and the operand is the returned word.
- R4: Mode 4 (memory indirect) makes two reads. The first is at the zero-extended field. The second is at the word it returned, which becomes `ea`; the second word is the operand.
- R5: Modes 5, 6 and 10 read at index register plus sign-extended field, primary plus index register, and primary register plus sign-extended field respectively. All sums wrap modulo 2^AW.
- R6: Mode 9 reads at `pc` plus the sign-extended field, wrapping modulo 2^AW, so a field with its top bit set moves the address backwards.
- R7: Mode 7 (post-increment) uses the primary register's old value as `ea`. The register then holds old value plus `esize`, and that value is visible to a request accepted in the `done` cycle.
- R8: Mode 8 (pre-decrement) lowers the primary register by `esize` and uses the lowered value as `ea`, with wrap below zero. The register holds the lowered value from the `done` cycle on.
- R9: Codes 11 to 15, and modes 7 or 8 with `esize` other than 1, 2 or 4, complete one cycle after `start` with `illegal` high. They make no memory request, leave the register file unchanged, and report `ea` and `operand` as zero.
- R10: `mem_req` stays high with a steady `mem_addr` until `mem_ack` is seen; an acknowledge in the request's first cycle is accepted. `done` rises in the cycle after the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when `busy` is low |
| mode | input | 4 | Addressing mode code |
| rsel | input | RW | Primary (base/pointer) register number |
| xsel | input | RW | Index register number |
| field | input | FW | Address or displacement field |
| pc | input | AW | Current program counter |
| esize | input | 3 | Element size for auto modes (1, 2 or 4) |
| rf_we | input | 1 | Register file write enable |
| rf_wsel | input | RW | Register file write number |
| rf_wdata | input | AW | Register file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | AW | Memory read data, valid with `mem_ack` |
| busy | output | 1 | A memory-mode request is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| ea | output | AW | Effective address |
| operand | output | AW | Operand value |
| illegal | output | 1 | The finished request used an illegal mode or size |

## Verification
The bench builds the unit with AW=16, FW=12 and NREG=8. Because the field is narrower than the word, both sign- and zero-extension of the field are visible. A 16-bit word lets wrap-around in indexed, based, PC-relative and pre-decrement sums be reached with small operands. The memory model answers after 0, 1 or 2 wait cycles, so the held-request and same-cycle-acknowledge cases of the handshake are both covered.

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit #(
  parameter int AW   = 16,
  parameter int FW   = 12,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [RW-1:0] rsel,
  input  logic [RW-1:0] xsel,
  input  logic [FW-1:0] field,
  input  logic [AW-1:0] pc,
  input  logic [2:0]    esize,
  input  logic          rf_we,
  input  logic [RW-1:0] rf_wsel,
  input  logic [AW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] operand,
  output logic          illegal
);
  localparam logic [3:0] M_IMM = 4'd0, M_REG = 4'd1, M_RIND = 4'd2, M_DIR = 4'd3,
                         M_MIND = 4'd4, M_IDX = 4'd5, M_BIDX = 4'd6, M_INC = 4'd7,
                         M_DEC = 4'd8, M_PCR = 4'd9, M_BASE = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_DATA} st_t;
  st_t st;

  logic [AW-1:0] rf [NREG];
  logic [AW-1:0] ea_q, op_q, nxt_q, ea_c;
  logic [3:0]    mode_q;
  logic [RW-1:0] rsel_q;
  logic          done_q, ill_q;

  wire [AW-1:0] sx   = {{(AW-FW){field[FW-1]}}, field};
  wire [AW-1:0] zx   = {{(AW-FW){1'b0}}, field};
  wire [AW-1:0] dsz  = AW'(esize);
  wire [AW-1:0] rr   = rf[rsel];
  wire [AW-1:0] rx   = rf[xsel];
  wire          dok  = (esize == 3'd1) || (esize == 3'd2) || (esize == 3'd4);
  wire          autm = (mode == M_INC) || (mode == M_DEC);
  wire          bad  = (mode > M_BASE) || (autm && !dok);
  wire          take = start && (st == S_IDLE);

  always_comb begin
    case (mode)
      M_RIND, M_INC: ea_c = rr;
      M_DIR, M_MIND: ea_c = zx;
      M_IDX:         ea_c = rx + sx;
      M_BIDX:        ea_c = rr + rx;
      M_DEC:         ea_c = rr - dsz;
      M_PCR:         ea_c = pc + sx;
      M_BASE:        ea_c = rr + sx;
      default:       ea_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ea_q   <= '0;
      op_q   <= '0;
      nxt_q  <= '0;
      mode_q <= M_IMM;
      rsel_q <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (rf_we) rf[rf_wsel] <= rf_wdata;
      case (st)
        S_IDLE: if (take) begin
          mode_q <= mode;
          rsel_q <= rsel;
          nxt_q  <= (mode == M_INC) ? rr + dsz : rr - dsz;
          ill_q  <= bad;
          ea_q   <= bad ? '0 : ea_c;
          if (bad || mode <= M_REG) begin
            done_q <= 1'b1;
            op_q   <= bad ? '0 : ((mode == M_IMM) ? sx : rr);
          end else begin
            st <= (mode == M_MIND) ? S_PTR : S_DATA;
          end
        end
        S_PTR: if (mem_ack) begin
          ea_q <= mem_rdata;
          st   <= S_DATA;
        end
        S_DATA: if (mem_ack) begin
          op_q   <= mem_rdata;
          done_q <= 1'b1;
          st     <= S_IDLE;
          if (mode_q == M_INC || mode_q == M_DEC) rf[rsel_q] <= nxt_q;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign mem_req  = busy;
  assign mem_addr = ea_q;
  assign done     = done_q;
  assign ea       = ea_q;
  assign operand  = op_q;
  assign illegal  = ill_q;

  AST_IMM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode == M_IMM |=> done && !mem_req && operand == $past(AW'($signed(field)))); // R2
  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode == M_DIR |=> mem_req && mem_addr == $past(AW'(field))); // R3
  AST_PCREL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode == M_PCR |=> mem_req && mem_addr == $past(pc + AW'($signed(field)))); // R6
  AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode > M_BASE |=> done && illegal && !mem_req); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
endmodule

// File: tb/sim_opnd_addr_unit.sv
`timescale 1ns/1ps
module sim_opnd_addr_unit;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, rf_we = 1'b0, mem_ack = 1'b0;
  logic [3:0]  mode = '0;
  logic [2:0]  rsel = '0, xsel = '0, rf_wsel = '0, esize = 3'd1;
  logic [11:0] field = '0;
  logic [15:0] pc = '0, rf_wdata = '0, mem_rdata = '0;
  logic        mem_req, busy, done, illegal;
  logic [15:0] mem_addr, ea, operand;
  logic [15:0] rfm [8];
  int checks = 0, fails = 0, cyc = 0;

  opnd_addr_unit #(.AW(16), .FW(12), .NREG(8)) u0 (
    .clk, .rst_n, .start, .mode, .rsel, .xsel, .field, .pc, .esize,
    .rf_we, .rf_wsel, .rf_wdata, .mem_req, .mem_addr, .mem_ack, .mem_rdata,
    .busy, .done, .ea, .operand, .illegal);

  always #2 clk = ~clk;

  function automatic logic [15:0] sx(logic [11:0] f);
    return {{4{f[11]}}, f};
  endfunction
  function automatic logic [15:0] memf(logic [15:0] a);
    return a * 16'd3 + 16'h0101;
  endfunction

  task automatic chk(string tag, string what, logic ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(int r, logic [15:0] v);
    rf_we = 1'b1; rf_wsel = 3'(r); rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    rfm[r] = v;
  endtask

  task automatic op(string tag, logic [3:0] m, int r, int x, logic [11:0] f,
                    logic [15:0] p, logic [2:0] d, int lat);
    logic [15:0] e_ea, e_op, a0, a1, wv;
    int nmem, ph, wc, wreg;
    logic e_ill, dok, fin, got, edone;
    e_ea = '0; e_op = '0; a0 = '0; a1 = '0; wv = '0;
    nmem = 0; wreg = -1; e_ill = 1'b0;
    dok = (d == 3'd1) || (d == 3'd2) || (d == 3'd4);
    case (m)
      4'd0: e_op = sx(f);
      4'd1: e_op = rfm[r];
      4'd2: begin nmem = 1; e_ea = rfm[r]; end
      4'd3: begin nmem = 1; e_ea = {4'h0, f}; end
      4'd4: begin nmem = 2; a0 = {4'h0, f}; e_ea = memf(a0); end
      4'd5: begin nmem = 1; e_ea = rfm[x] + sx(f); end
      4'd6: begin nmem = 1; e_ea = rfm[r] + rfm[x]; end
      4'd7: begin nmem = 1; e_ea = rfm[r]; wreg = r; wv = rfm[r] + 16'(d); end
      4'd8: begin nmem = 1; e_ea = rfm[r] - 16'(d); wreg = r; wv = e_ea; end
      4'd9: begin nmem = 1; e_ea = p + sx(f); end
      4'd10: begin nmem = 1; e_ea = rfm[r] + sx(f); end
      default: e_ill = 1'b1;
    endcase
    if ((m == 4'd7 || m == 4'd8) && !dok) begin
      e_ill = 1'b1; nmem = 0; wreg = -1; e_ea = '0;
    end
    if (nmem == 1) a0 = e_ea;
    a1 = e_ea;
    if (nmem > 0) e_op = memf(e_ea);
    mode = m; rsel = 3'(r); xsel = 3'(x); field = f; pc = p; esize = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ph = 0; wc = 0; got = 1'b0; fin = (nmem == 0);
    for (int c = 0; c < 40 && !got; c++) begin
      edone = fin; fin = 1'b0;
      chk(tag, "done timing", done == edone, done, edone);
      if (done) begin
        got = 1'b1; mem_ack = 1'b0;
        chk(tag, "mem_req at done", !mem_req, mem_req, 0);
        chk(tag, "operand", operand == e_op, operand, e_op);
        chk(tag, "ea", ea == e_ea, ea, e_ea);
        chk(tag, "illegal", illegal == e_ill, illegal, e_ill);
        if (wreg >= 0) rfm[wreg] = wv;
      end else begin
        chk(tag, "mem_req", mem_req == (ph < nmem), mem_req, ph < nmem);
        if (mem_req) begin
          chk(tag, "mem_addr", mem_addr == ((ph == 0) ? a0 : a1), mem_addr, (ph == 0) ? a0 : a1);
          if (wc >= lat) begin
            mem_ack = 1'b1; mem_rdata = memf(mem_addr); ph++; wc = 0;
            if (ph == nmem) fin = 1'b1;
          end else begin
            mem_ack = 1'b0; wc++;
          end
        end else mem_ack = 1'b0;
        @(negedge clk);
      end
    end
    if (!got) chk(tag, "no done within timeout", 1'b0, 0, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rfm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset outputs", !done && !busy && !mem_req && !illegal,
        {done, busy, mem_req, illegal}, 0);
    op("R1", 4'd1, 5, 0, 12'h000, 16'h0, 3'd1, 0);
    op("R1", 4'd1, 0, 0, 12'h000, 16'h0, 3'd1, 0);

    wr(1, 16'h1000); wr(2, 16'h0004); wr(3, 16'h0000); wr(4, 16'h7FF0); wr(5, 16'hFFFE);

    op("R2", 4'd0, 0, 0, 12'h7FF, 16'h0, 3'd1, 0);
    op("R2", 4'd0, 0, 0, 12'h800, 16'h0, 3'd1, 0);
    op("R2", 4'd1, 4, 0, 12'h000, 16'h0, 3'd1, 0);

    op("R3", 4'd2, 1, 0, 12'h000, 16'h0, 3'd1, 0);
    op("R3", 4'd3, 0, 0, 12'hABC, 16'h0, 3'd1, 1);
    op("R10", 4'd2, 4, 0, 12'h000, 16'h0, 3'd1, 2);

    op("R4", 4'd4, 0, 0, 12'h020, 16'h0, 3'd1, 1);
    op("R4", 4'd4, 0, 0, 12'hF00, 16'h0, 3'd1, 0);

    op("R5", 4'd5, 0, 2, 12'hFFE, 16'h0, 3'd1, 0);
    op("R5", 4'd6, 4, 5, 12'h000, 16'h0, 3'd1, 1);
    op("R5", 4'd10, 5, 0, 12'h010, 16'h0, 3'd1, 0);

    op("R6", 4'd9, 0, 0, 12'hFF0, 16'h0008, 3'd1, 0);
    op("R6", 4'd9, 0, 0, 12'h020, 16'hFFF0, 3'd1, 2);

    op("R7", 4'd7, 1, 0, 12'h000, 16'h0, 3'd2, 0);
    op("R7", 4'd7, 1, 0, 12'h000, 16'h0, 3'd4, 1);
    op("R7", 4'd1, 1, 0, 12'h000, 16'h0, 3'd1, 0);

    op("R8", 4'd8, 3, 0, 12'h000, 16'h0, 3'd4, 0);
    op("R8", 4'd1, 3, 0, 12'h000, 16'h0, 3'd1, 0);
    op("R8", 4'd8, 3, 0, 12'h000, 16'h0, 3'd1, 2);
    op("R7", 4'd7, 3, 0, 12'h000, 16'h0, 3'd1, 0);
    op("R7", 4'd7, 3, 0, 12'h000, 16'h0, 3'd4, 0);
    op("R8", 4'd1, 3, 0, 12'h000, 16'h0, 3'd1, 0);

    for (int k = 11; k < 16; k++) op("R9", 4'(k), 1, 2, 12'h123, 16'h0, 3'd1, 0);
    op("R9", 4'd7, 1, 0, 12'h000, 16'h0, 3'd3, 0);
    op("R9", 4'd8, 2, 0, 12'h000, 16'h0, 3'd0, 0);
    op("R9", 4'd1, 1, 0, 12'h000, 16'h0, 3'd1, 0);
    op("R9", 4'd1, 2, 0, 12'h000, 16'h0, 3'd1, 0);

    op("R10", 4'd4, 0, 0, 12'h044, 16'h0, 3'd1, 2);
    op("R10", 4'd9, 0, 0, 12'h001, 16'h0100, 3'd1, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule